// File: doc/BRIEF.md
# Dual-Channel Interval Timer

The block holds two independent 32-bit timer channels behind a simple register bus. Each bus transfer is a single word, with no byte lanes. Each channel has a control/status word, a load value and a counter that software can read. A channel counts up or down once per clock while it runs. At its terminal value it either reloads from the load value and keeps going, or it stops there.

Reaching the terminal value sets a sticky event flag in the channel's control word. Writing a 1 to that flag clears it. The block drives a single interrupt line, which is the OR over both channels of the flag gated by that channel's interrupt enable.

Typical uses:
- A down-counting channel with reload gives a periodic tick.
- An up-counting channel with reload from zero, and no interrupt, gives a free-running cycle counter.
- A channel without reload gives a one-shot delay.

Writes land on the rising clock edge. Reads are combinational from the addressed register.

Top module: `dual_timer`

## Requirements
- R1: After reset, every control, load and counter register of both channels reads 0, and irq_o is 0.
- R2: The word address `addr_i` selects the register. Bit 2 selects the channel. Bits 1:0 select control (0), load (1) or counter (2). Code 3 reads 0. The control word uses these bits: 0 mode, 1 count down, 2 and 3 external enables, 4 reload, 5 force-load, 6 interrupt enable, 7 run, 8 event flag, 9 pwm, 10 run-all. Bits 31:11 read 0. The load register reads back what was written.
- R3: While force-load is 1, the counter takes the load value on every clock, even if run is 1. Counting starts only after force-load is written back to 0.
- R4: The counter steps by one per clock only while run is 1, up or down according to bit 1. Clearing run freezes the counter.
- R5: Writing 1 to a set event flag clears it. Writing back the control word just read acknowledges the event and keeps every other setting.
- R6: With reload set, the counter reloads at terminal count and keeps running. A down-counting channel loaded with L flags an event every L+1 clocks.
- R7: An up-counting channel with reload from 0 and no interrupt enable runs freely and wraps from 0xFFFFFFFF to 0 without asserting irq_o.
- R8: irq_o is the OR over both channels of (event flag AND interrupt enable).
- R9: Terminal count is 0x00000000 when counting down and 0xFFFFFFFF when counting up. It is taken in the clock where a running channel holds that value, and it sets the flag. If software clears the flag in that same clock, the set wins.
- R10: With reload clear, the counter holds at terminal count and run clears itself.
- R11: Writing a control word with run-all set sets run in both channels on that clock.
- R12: Writes to a counter register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt |

## Verification
A software acknowledge write to the control word can land in the same clock where the channel reaches terminal count. The flag clear from the write and the flag set from the terminal count then fall on one edge.

The bench counts clocks through a running periodic channel. It times the write-back of the control word to land exactly on a reload edge. It then expects the flag still set and irq_o high. A channel in which the clear beats the set is reported as a failure.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W   = 11;
  localparam int B_MODE   = 0;
  localparam int B_DOWN   = 1;
  localparam int B_EXTGEN = 2;
  localparam int B_EXTCAP = 3;
  localparam int B_RELOAD = 4;
  localparam int B_LOAD   = 5;
  localparam int B_IRQEN  = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;
  localparam int B_PWM    = 9;
  localparam int B_ALL    = 10;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_load_i,
  input  logic         run_i,
  input  logic         down_i,
  input  logic         reload_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] tc_val;

  assign tc_val = down_i ? '0 : '1;
  assign tc_o   = run_i && !hold_load_i && (cnt_o == tc_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (hold_load_i) begin
      cnt_o <= load_val_i;
    end else if (run_i) begin
      if (tc_o) begin
        if (reload_i) cnt_o <= load_val_i;
      end else begin
        cnt_o <= down_i ? cnt_o - ONE : cnt_o + ONE;
      end
    end
  end

  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_load_i |=> cnt_o == $past(load_val_i));

  assert_freeze_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !hold_load_i) |=> $stable(cnt_o));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hold_load_i && !tc_o) |=>
      cnt_o == ($past(down_i) ? $past(cnt_o) - ONE : $past(cnt_o) + ONE));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              load_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              run_force_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              run_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] load_q;
  logic              tc;

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_load_i (ctrl_q[B_LOAD]),
    .run_i       (ctrl_q[B_RUN]),
    .down_i      (ctrl_q[B_DOWN]),
    .reload_i    (ctrl_q[B_RELOAD]),
    .load_val_i  (load_q),
    .cnt_o       (cnt_o),
    .tc_o        (tc)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we_i) begin
      ctrl_d         = wdata_i[CTRL_W-1:0];
      ctrl_d[B_FLAG] = ctrl_q[B_FLAG] & ~wdata_i[B_FLAG];
    end
    if (tc) begin
      ctrl_d[B_FLAG] = 1'b1;                 // set beats clear
      if (!ctrl_q[B_RELOAD] && !ctrl_we_i) ctrl_d[B_RUN] = 1'b0;
    end
    if (run_force_i) ctrl_d[B_RUN] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (load_we_i) load_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign run_o  = ctrl_q[B_RUN];
  assign irq_o  = ctrl_q[B_FLAG] & ctrl_q[B_IRQEN];

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |=> ctrl_q[B_FLAG]);

  assert_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[B_FLAG] && !tc) |=> !ctrl_q[B_FLAG]);

  assert_oneshot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && !ctrl_q[B_RELOAD] && !ctrl_we_i && !run_force_i) |=> !ctrl_q[B_RUN]);
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0]             ctrl_we, load_we, irq_vec, run_vec;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v;
  logic [NUM_CH-1:0][DATA_W-1:0] load_v, cnt_v;
  logic                          run_force;
  logic [CH_W-1:0]               ch_sel;
  reg_sel_e                      reg_sel;

  assign ch_sel  = CH_W'(addr_i[2]);
  assign reg_sel = reg_sel_e'(addr_i[1:0]);
  assign run_force = (|ctrl_we) & wdata_i[B_ALL];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ctrl_we[c] = wr_en_i && (ch_sel == CH_W'(c)) && (reg_sel == REG_CTRL);
    assign load_we[c] = wr_en_i && (ch_sel == CH_W'(c)) && (reg_sel == REG_LOAD);

    tmr_channel #(.DATA_W(DATA_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ctrl_we_i   (ctrl_we[c]),
      .load_we_i   (load_we[c]),
      .wdata_i     (wdata_i),
      .run_force_i (run_force),
      .ctrl_o      (ctrl_v[c]),
      .load_o      (load_v[c]),
      .cnt_o       (cnt_v[c]),
      .run_o       (run_vec[c]),
      .irq_o       (irq_vec[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        case (reg_sel)
          REG_CTRL:  rdata_o = DATA_W'(ctrl_v[c]);
          REG_LOAD:  rdata_o = load_v[c];
          REG_COUNT: rdata_o = cnt_v[c];
          default:   rdata_o = '0;
        endcase
      end
    end
  end

  assign irq_o = |irq_vec;

  assert_run_all_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_force |=> &run_vec);

  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_vec == '0) |-> !irq_o);
endmodule

// File: tb/dual_timer_tb_top.sv
module dual_timer_tb_top;
  localparam int PERIOD = 20;
  localparam logic [2:0] A_CTRL0 = 3'd0, A_LOAD0 = 3'd1, A_CNT0 = 3'd2, A_NONE = 3'd3;
  localparam logic [2:0] A_CTRL1 = 3'd4, A_LOAD1 = 3'd5, A_CNT1 = 3'd6;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  item_t sb_q[$];
  event  mon_ev;

  always #(PERIOD/2) clk = ~clk;

  dual_timer dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  // monitor: pops expected items and compares against the ports
  always begin
    @(mon_ev);
    #1;
    begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fails++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
    #2;
  endtask

  // applied on the next rising edge; returns at the following falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    exp_rd(A_CTRL0, 32'h0, "R1 ctrl0");
    exp_rd(A_CNT0,  32'h0, "R1 cnt0");
    exp_irq(1'b0, "R1 irq");
    cyc(1);
    exp_rd(A_CTRL1, 32'h0, "R1 ctrl1");
    exp_rd(A_LOAD1, 32'h0, "R1 load1");
    exp_rd(A_NONE,  32'h0, "R2 unused code");

    // R3 force-load holds counter even with run set
    wr(A_LOAD0, 32'd5);
    exp_rd(A_LOAD0, 32'd5, "R2 load readback");
    wr(A_CTRL0, 32'h20);
    cyc(1);
    exp_rd(A_CNT0, 32'd5, "R3 forced load");
    wr(A_CTRL0, 32'hA2);
    cyc(3);
    exp_rd(A_CNT0, 32'd5, "R3 no count while load held");

    // R6 periodic down count, load 5 -> period 6
    wr(A_CTRL0, 32'hD2);
    cyc(5);
    exp_rd(A_CNT0, 32'd0, "R9 reaches zero");
    exp_irq(1'b0, "R9 flag not yet set");
    cyc(1);
    exp_rd(A_CNT0, 32'd5, "R6 reload");
    exp_irq(1'b1, "R8 irq on flag");
    exp_rd(A_CTRL0, 32'h1D2, "R9 flag set");
    // R5 write-back acknowledge
    wr(A_CTRL0, 32'h1D2);
    exp_rd(A_CTRL0, 32'hD2, "R5 ack keeps settings");
    exp_rd(A_CNT0, 32'd4, "R5 counting continues");
    exp_irq(1'b0, "R5 irq cleared");
    cyc(5);
    exp_rd(A_CNT0, 32'd5, "R6 second reload after L+1");
    exp_irq(1'b1, "R6 second event");
    // R9 ack lands on terminal-count edge: set wins
    cyc(5);
    wr(A_CTRL0, 32'h1D2);
    exp_rd(A_CTRL0, 32'h1D2, "R9 set beats clear");
    exp_irq(1'b1, "R9 irq stays");
    exp_rd(A_CNT0, 32'd5, "R6 third reload");
    // R4 stop and freeze
    wr(A_CTRL0, 32'h100);
    exp_rd(A_CNT0, 32'd4, "R4 last step");
    cyc(3);
    exp_rd(A_CNT0, 32'd4, "R4 frozen");
    exp_rd(A_CTRL0, 32'h0, "R4 ctrl cleared");

    // R10 one-shot up count on channel 1
    wr(A_LOAD1, 32'hFFFF_FFFD);
    wr(A_CTRL1, 32'h20);
    wr(A_CTRL1, 32'hC0);
    cyc(2);
    exp_rd(A_CNT1, 32'hFFFF_FFFF, "R4 up count");
    exp_irq(1'b0, "R10 before tc");
    cyc(1);
    exp_rd(A_CTRL1, 32'h140, "R10 run cleared, flag set");
    exp_irq(1'b1, "R10 irq");
    cyc(2);
    exp_rd(A_CNT1, 32'hFFFF_FFFF, "R10 holds at terminal");
    wr(A_CTRL1, 32'h140);
    exp_rd(A_CTRL1, 32'h40, "R5 ack one-shot");

    // R7 free-running wrap, no interrupt
    wr(A_LOAD1, 32'hFFFF_FFFE);
    wr(A_CTRL1, 32'h20);
    wr(A_CTRL1, 32'h90);
    wr(A_LOAD1, 32'h0);
    exp_rd(A_CNT1, 32'hFFFF_FFFF, "R7 top value");
    cyc(1);
    exp_rd(A_CNT1, 32'h0, "R7 wraps to zero");
    exp_irq(1'b0, "R7 R8 no irq without enable");
    cyc(1);
    exp_rd(A_CNT1, 32'h1, "R7 keeps running");
    wr(A_CTRL1, 32'h100);
    exp_rd(A_CNT1, 32'h2, "R4 ch1 stopped");

    // R11 run-all, R2 reserved bits read 0
    wr(A_CTRL0, 32'hFFFF_F402);
    exp_rd(A_CTRL0, 32'h482, "R2 R11 ctrl0");
    exp_rd(A_CTRL1, 32'h80, "R11 ch1 run set");
    cyc(1);
    exp_rd(A_CNT0, 32'd3, "R11 ch0 counts down");
    exp_rd(A_CNT1, 32'd3, "R11 ch1 counts up");

    // R12 counter write ignored
    wr(A_CNT0, 32'h1234_5678);
    exp_rd(A_CNT0, 32'd2, "R12 counter write ignored");
    exp_rd(A_LOAD0, 32'd5, "R12 load untouched");

    cyc(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule